// File: doc/BRIEF.md
# Bitplane to Color-Index Serializer

This block turns planar display data into a stream of per-pixel color indices. On each accepted transfer it takes one data word for every bitplane, all at once. It then shifts every plane word left in lockstep. For each pixel it gathers the current leading bit of every plane into one index. Plane 0 gives the least significant index bit, and the leftmost pixel of a word is the word's most significant bit.

The input side is a valid/ready channel that carries the plane words and the number of active planes. The output side is a valid/ready channel of color indices, and its ready acts as the pixel-clock enable. A new word set is taken when the shifter is empty. It is also taken on the cycle that consumes the last pixel of the current set, so that consecutive word sets form an unbroken pixel stream. Palette lookup, display timing and fine scrolling belong to other blocks.

Top module: `bitplane_serializer`

## Requirements
- R1: Bit p of `idx` is taken from the word of plane p. Plane p's word occupies `plane_words[p*WORD_W +: WORD_W]`, and plane 0 supplies bit 0 of the index.
- R2: Pixels within a word leave most significant bit first. Pixel k (k = 0 for the first pixel after acceptance) uses bit WORD_W-1-k of each active plane word.
- R3: `depth` gives the number of active planes. Index bits for planes p >= depth read as 0. A depth of 0 yields an all-zero index, and values above NUM_PLANES act as NUM_PLANES.
- R4: `depth` and `plane_words` are sampled only on an accepted transfer (`word_valid && word_ready`). Changing them at any other time has no effect on the index stream.
- R5: After an accepted transfer, `idx_valid` stays high for exactly WORD_W accepted pixels (`idx_valid && idx_ready`). It then drops unless another transfer was accepted.
- R6: `word_ready` is high when no pixel is pending. It is also high when exactly one pixel is pending and `idx_ready` is high. It is low at all other times. A transfer accepted on the last pixel continues the stream with no gap and no repeated pixel.
- R7: `word_valid` asserted while `word_ready` is low has no effect, and the pending pixels come out unchanged.
- R8: While `idx_valid` is high and `idx_ready` is low, `idx` and `idx_valid` hold their values.
- R9: While `rst_n` is low, and on the first cycle after reset, `idx_valid` is 0, `idx` is 0 and `word_ready` is 1.
- R10: `idx` reads 0 whenever `idx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | A word set is offered |
| word_ready | output | 1 | The block accepts the offered word set this cycle |
| plane_words | input | NUM_PLANES*WORD_W | One word per plane, plane p at bits p*WORD_W upward |
| depth | input | $clog2(NUM_PLANES+1) | Number of active planes in the offered set |
| idx_valid | output | 1 | A color index is presented |
| idx_ready | input | 1 | Pixel enable: the presented index is consumed |
| idx | output | NUM_PLANES | Color index of the current pixel |

## Verification
The bench builds the block with its defaults: eight planes, 16-bit words and a 4-bit depth field. This lets it sweep every depth from 0 through 15, including the codes above eight that must clamp. With a full eight-plane word, each of the eight index bits can be traced to its own plane. The 16-pixel word length keeps the hand-off between consecutive words frequent. That brings the last-pixel reload, and its collision with a stalled pixel enable, into reach many times in a short run.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } shift_op_e;
endpackage

// File: rtl/bps_plane_mask.sv
module bps_plane_mask #(
  parameter int NUM_PLANES = 8,
  parameter int DEPTH_W    = $clog2(NUM_PLANES + 1)
) (
  input  logic [DEPTH_W-1:0]    depth,
  output logic [NUM_PLANES-1:0] active
);
  // a plane is live when its number is below the requested depth;
  // oversized depth codes simply enable every plane
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    assign active[p] = (32'(depth) > p);
  end
endmodule

// File: rtl/bps_plane_shifter.sv
module bps_plane_shifter
  import bps_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shift_op_e         op,
  input  logic              plane_on,
  input  logic [WORD_W-1:0] word_in,
  output logic              lead_bit
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  sr <= plane_on ? word_in : '0;
        OP_SHIFT: sr <= {sr[WORD_W-2:0], 1'b0};
        default:  sr <= sr;
      endcase
    end
  end

  assign lead_bit = sr[WORD_W-1];
endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      word_valid,
  input  logic      idx_ready,
  output logic      word_ready,
  output logic      idx_valid,
  output shift_op_e op
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] pending;
  logic             take_word;
  logic             advance;

  assign idx_valid  = (pending != '0);
  assign advance    = idx_valid && idx_ready;
  assign word_ready = !idx_valid || (pending == ONE && idx_ready);
  assign take_word  = word_valid && word_ready;

  always_comb begin
    if (take_word)    op = OP_LOAD;
    else if (advance) op = OP_SHIFT;
    else              op = OP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= '0;
    else if (take_word) pending <= FULL;
    else if (advance)   pending <= pending - ONE;
  end
endmodule

// File: rtl/bitplane_serializer.sv
module bitplane_serializer
  import bps_pkg::*;
#(
  parameter int NUM_PLANES = 8,
  parameter int WORD_W     = 16,
  localparam int DEPTH_W   = $clog2(NUM_PLANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_valid,
  output logic                         word_ready,
  input  logic [NUM_PLANES*WORD_W-1:0] plane_words,
  input  logic [DEPTH_W-1:0]           depth,
  output logic                         idx_valid,
  input  logic                         idx_ready,
  output logic [NUM_PLANES-1:0]        idx
);
  shift_op_e             op;
  logic [NUM_PLANES-1:0] active;

  bps_ctrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .idx_ready  (idx_ready),
    .word_ready (word_ready),
    .idx_valid  (idx_valid),
    .op         (op)
  );

  bps_plane_mask #(.NUM_PLANES(NUM_PLANES), .DEPTH_W(DEPTH_W)) i_mask (
    .depth  (depth),
    .active (active)
  );

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_shift
    bps_plane_shifter #(.WORD_W(WORD_W)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .plane_on (active[p]),
      .word_in  (plane_words[p*WORD_W +: WORD_W]),
      .lead_bit (idx[p])
    );
  end
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
  parameter int NUM_PLANES = 8,
  parameter int WORD_W     = 16,
  parameter int DEPTH_W    = $clog2(NUM_PLANES + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  word_valid,
  input logic                  word_ready,
  input logic [DEPTH_W-1:0]    depth,
  input logic                  idx_valid,
  input logic                  idx_ready,
  input logic [NUM_PLANES-1:0] idx
);
  int unsigned           left_cnt;
  int unsigned           depth_seen;
  logic [NUM_PLANES-1:0] allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_cnt   <= 0;
      depth_seen <= 0;
    end else if (word_valid && word_ready) begin
      left_cnt   <= WORD_W;
      depth_seen <= 32'(depth);
    end else if (idx_valid && idx_ready && left_cnt != 0) begin
      left_cnt <= left_cnt - 1;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PLANES; p++) allowed[p] = (depth_seen > p);
  end

  // R5
  valid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid == (left_cnt != 0));

  // R3
  masked_planes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx & ~allowed) == '0);

  // R6
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_valid |-> word_ready);

  // R6
  take_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> idx_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !idx_ready) |=> (idx_valid && $stable(idx)));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_valid |-> (idx == '0));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!idx_valid && word_ready));
endmodule

bind bitplane_serializer bps_checker #(
  .NUM_PLANES (NUM_PLANES),
  .WORD_W     (WORD_W),
  .DEPTH_W    (DEPTH_W)
) i_bps_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .depth      (depth),
  .idx_valid  (idx_valid),
  .idx_ready  (idx_ready),
  .idx        (idx)
);

// File: tb/test_bitplane_serializer.sv
`timescale 1ns/1ps
module test_bitplane_serializer;
  localparam int NP = 8;
  localparam int WW = 16;
  localparam int DW = 4;
  localparam int WATCHDOG = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             word_valid = 1'b0;
  logic             word_ready;
  logic [NP*WW-1:0] plane_words = '0;
  logic [DW-1:0]    depth = '0;
  logic             idx_valid;
  logic             idx_ready = 1'b0;
  logic [NP-1:0]    idx;

  always #2.5 clk = ~clk;

  bitplane_serializer i_bitplane_serializer (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .plane_words(plane_words), .depth(depth), .idx_valid(idx_valid),
    .idx_ready(idx_ready), .idx(idx)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference: pixels left, stored words, stored depth
  int          m_left = 0;
  logic [WW-1:0] m_w [NP];
  int          m_d = 0;

  initial for (int p = 0; p < NP; p++) m_w[p] = '0;

  function automatic logic m_ready();
    return (m_left == 0) || (m_left == 1 && idx_ready);
  endfunction

  function automatic logic [NP-1:0] m_idx();
    logic [NP-1:0] e = '0;
    if (m_left > 0)
      for (int p = 0; p < NP; p++)
        if (p < m_d) e[p] = m_w[p][m_left-1];
    return e;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_left = 0;
    end else if (word_valid && m_ready()) begin
      m_left = WW;
      for (int p = 0; p < NP; p++) m_w[p] = plane_words[p*WW +: WW];
      m_d = (int'(depth) > NP) ? NP : int'(depth);
    end else if (idx_ready && m_left > 0) begin
      m_left--;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  // one cycle: drive at the falling edge, compare a little later
  task automatic step(logic wv, logic [NP*WW-1:0] w, logic [DW-1:0] d, logic rdy, string tag);
    @(negedge clk);
    word_valid  = wv;
    plane_words = w;
    depth       = d;
    idx_ready   = rdy;
    #1;
    check({"R5 valid ", tag}, 32'(idx_valid), 32'(m_left > 0));
    check({"R6 ready ", tag}, 32'(word_ready), 32'(m_ready()));
    check({"index ", tag}, 32'(idx), 32'(m_idx()));
  endtask

  function automatic logic [NP*WW-1:0] rnd_words();
    logic [NP*WW-1:0] r;
    for (int i = 0; i < NP*WW/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    logic [NP*WW-1:0] w;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 valid in reset", 32'(idx_valid), 32'd0);
    check("R9 idx in reset", 32'(idx), 32'd0);
    check("R9 ready in reset", 32'(word_ready), 32'd1);
    rst_n = 1'b1;
    step(1'b0, '0, 4'd8, 1'b1, "R9 after reset");

    // R1: plane p holds a single bit at pixel p -> index 1<<p
    w = '0;
    for (int p = 0; p < NP; p++) w[p*WW + (WW-1-p)] = 1'b1;
    step(1'b1, w, 4'd8, 1'b1, "R1 load");
    for (int k = 0; k < WW + 4; k++) step(1'b0, '0, 4'd8, 1'b1, "R1 R10 drain");

    // R2: one plane, asymmetric pattern, MSB first
    w = '0;
    w[WW-1:0] = 16'hC5A3;
    step(1'b1, w, 4'd1, 1'b1, "R2 load");
    for (int k = 0; k < WW + 2; k++) step(1'b0, '0, 4'd1, 1'b1, "R2 order");

    // R3: every depth code, including 0 and codes above NP
    for (int d = 0; d < 16; d++) begin
      step(1'b1, rnd_words(), DW'(d), 1'b1, "R3 load");
      for (int k = 0; k < WW; k++) step(1'b0, rnd_words(), DW'(15 - d), 1'b1, "R3 R4 depth");
    end

    // R6: back-to-back stream, word_valid always high
    for (int k = 0; k < 8*WW; k++) step(1'b1, rnd_words(), 4'd8, 1'b1, "R6 stream");

    // R7 + R4: offers while busy are ignored
    for (int k = 0; k < 4*WW; k++)
      step(1'b1, rnd_words(), DW'($urandom_range(0, 15)), (k % WW) == 0, "R7 R4 busy offer");

    // R8: random back-pressure and offers
    for (int k = 0; k < 3000; k++)
      step(($urandom % 3) != 0, rnd_words(), DW'($urandom_range(0, 15)),
           ($urandom % 4) != 0, "R8 random");

    // R8: long stall with pixels pending, then drain
    step(1'b1, rnd_words(), 4'd5, 1'b1, "R8 load");
    for (int k = 0; k < 10; k++) step(1'b0, '0, 4'd5, 1'b0, "R8 stall");
    for (int k = 0; k < WW + 2; k++) step(1'b0, '0, 4'd5, 1'b1, "R8 R10 drain");

    summary();
    $finish;
  end
endmodule